// File: doc/BRIEF.md
# Chainable Serial Dual-Wiper Setting Controller

This block is the digital side of a dual 8-bit wiper setting device. A host drives it over a three-wire serial port: an active-high enable line that frames a transaction, a serial clock, and a data line. While the enable line is high, each rising serial clock shifts one data bit into a 17-bit frame register. The frame holds a stack-select flag and two 8-bit wiper codes. When the enable line falls, the frame is copied into holding registers. These registers drive the two wiper codes, the stack-select flag and a selected-wiper code, which is the wiper picked by the flag.

The lowest frame bit is always presented on a cascade output. Several devices can be chained by wiring each cascade output to the next device's data input, with 17 clocks per device in the chain. If the last cascade output is looped back to the first data input, 17 x N clocks return every frame to where it started. This lets the host read the settings back without disturbing them.

The three serial lines are asynchronous to the system clock. Each passes through its own synchronizer, and edges are detected on the synchronized copies.

Top module: `wiper_serial_ctrl`

## Requirements
- R1: While the serial enable is low, serial clock edges and data changes leave the frame register, the cascade output and all setting outputs unchanged.
- R2: While the serial enable is high, each rising serial clock shifts the frame one position toward bit 0 and puts the sampled data bit into bit 16. After 17 clocks the first bit sent sits in bit 0.
- R3: Frame layout: bit 0 is the stack-select flag. Bits 1 to 8 hold the wiper-1 code, with its MSB in bit 1. Bits 9 to 16 hold the wiper-0 code, with its MSB in bit 9. On the wire this means the flag goes first, then wiper 1 MSB first, then wiper 0 MSB first.
- R4: The wiper codes and the stack-select output change only when the serial enable falls, and then take the frame contents. They hold their values throughout a transaction.
- R5: The cascade output always equals frame bit 0. A three-device loop clocked 51 times returns the original frames, and the bits read back are each device's frame from bit 0 upward, starting with the device farthest down the chain.
- R6: The selected-wiper output equals the wiper-0 code when the stack-select flag is 0 and the wiper-1 code when it is 1.
- R7: Synchronous reset clears the frame register, the holding registers and all outputs to zero.
- R8: A transaction with fewer than 17 clocks still transfers the partly shifted frame when the enable falls. Bits are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Serial transaction enable, active high (asynchronous) |
| ser_clk | input | 1 | Serial shift clock, rising edge active (asynchronous) |
| ser_data | input | 1 | Serial data in (asynchronous) |
| cascade_out | output | 1 | Frame bit 0, for the next device or for loopback |
| wiper0_code | output | 8 | Held wiper-0 code |
| wiper1_code | output | 8 | Held wiper-1 code |
| stack_sel | output | 1 | Held stack-select flag |
| wiper_sel_code | output | 8 | Wiper code chosen by the stack-select flag |

## Verification
A wrong frame register shows up first at the cascade output, a few system clocks after the next serial clock edge. In a chain or a looped read, that wrong bit then reaches the read-back stream and the neighbouring devices. A wrong holding register, or a load taken at the wrong moment, shows at the wiper outputs. It appears either during a transaction, where the outputs should be frozen, or within a few system clocks after the enable falls. The bench therefore compares every setting output on every clock and checks the cascade output after each shift.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
    localparam int WIPER_W = 8;
    localparam int FRAME_W = 2 * WIPER_W + 1;
    localparam int W1_BASE = 1;
    localparam int W0_BASE = 1 + WIPER_W;

    typedef logic [WIPER_W-1:0] code_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic  stack;
        code_t w1;
        code_t w0;
    } settings_t;

    // Fields are stored MSB at the lowest frame index.
    function automatic settings_t frame_to_settings(frame_t f);
        settings_t s;
        s.stack = f[0];
        for (int k = 0; k < WIPER_W; k++) begin
            s.w1[WIPER_W-1-k] = f[W1_BASE+k];
            s.w0[WIPER_W-1-k] = f[W0_BASE+k];
        end
        return s;
    endfunction

    function automatic code_t pick_code(settings_t s);
        return s.stack ? s.w1 : s.w0;
    endfunction
endpackage

// File: rtl/wsc_sync.sv
module wsc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else if (g == 0) stage_q[g] <= din;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/wsc_frontend.sv
module wsc_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_raw,
    input  logic sclk_raw,
    input  logic data_raw,
    output logic en_lvl,
    output logic shift_pulse,
    output logic en_fall,
    output logic data_bit
);
    localparam int NLINES = 3;
    logic [NLINES-1:0] raw_v, sync_v;
    logic sclk_lvl, en_q, sclk_q;

    assign raw_v = {en_raw, sclk_raw, data_raw};

    wsc_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_v),
        .dout(sync_v)
    );

    assign {en_lvl, sclk_lvl, data_bit} = sync_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            en_q   <= en_lvl;
            sclk_q <= sclk_lvl;
        end
    end

    assign shift_pulse = en_lvl & sclk_lvl & ~sclk_q;
    assign en_fall     = en_q & ~en_lvl;
endmodule

// File: rtl/wsc_shifter.sv
module wsc_shifter
    import wsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   shift_pulse,
    input  logic   data_bit,
    output frame_t frame,
    output logic   casc_bit
);
    always_ff @(posedge clk) begin
        if (rst) frame <= '0;
        else if (shift_pulse) frame <= {data_bit, frame[FRAME_W-1:1]};
    end

    assign casc_bit = frame[0];
endmodule

// File: rtl/wsc_hold.sv
module wsc_hold
    import wsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  frame_t    frame,
    output settings_t held,
    output code_t     sel_code
);
    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else if (load) held <= frame_to_settings(frame);
    end

    assign sel_code = pick_code(held);
endmodule

// File: rtl/wiper_serial_ctrl.sv
module wiper_serial_ctrl
    import wsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_en,
    input  logic               ser_clk,
    input  logic               ser_data,
    output logic               cascade_out,
    output logic [WIPER_W-1:0] wiper0_code,
    output logic [WIPER_W-1:0] wiper1_code,
    output logic               stack_sel,
    output logic [WIPER_W-1:0] wiper_sel_code
);
    logic      en_lvl, shift_pulse, en_fall, data_bit;
    frame_t    sreg;
    settings_t held;

    wsc_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk        (clk),
        .rst        (rst),
        .en_raw     (ser_en),
        .sclk_raw   (ser_clk),
        .data_raw   (ser_data),
        .en_lvl     (en_lvl),
        .shift_pulse(shift_pulse),
        .en_fall    (en_fall),
        .data_bit   (data_bit)
    );

    wsc_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .shift_pulse(shift_pulse),
        .data_bit   (data_bit),
        .frame      (sreg),
        .casc_bit   (cascade_out)
    );

    wsc_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (en_fall),
        .frame   (sreg),
        .held    (held),
        .sel_code(wiper_sel_code)
    );

    assign wiper0_code = held.w0;
    assign wiper1_code = held.w1;
    assign stack_sel   = held.stack;
endmodule

// File: rtl/wsc_chk.sv
module wsc_chk
    import wsc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               en_lvl,
    input logic               shift_pulse,
    input logic               en_fall,
    input logic [FRAME_W-1:0] sreg,
    input logic               cascade_out,
    input logic [WIPER_W-1:0] wiper0_code,
    input logic [WIPER_W-1:0] wiper1_code,
    input logic               stack_sel
);
    // R1
    shift_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |-> en_lvl);

    // R1
    frame_idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_pulse |=> $stable(sreg));

    // R2
    frame_moves_down_chk: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> sreg[FRAME_W-2:0] == $past(sreg[FRAME_W-1:1]));

    // R5
    cascade_next_bit_chk: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> cascade_out == $past(sreg[1]));

    // R4
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !en_fall |=> $stable(wiper0_code) && $stable(wiper1_code) && $stable(stack_sel));

    // R4
    hold_takes_frame_chk: assert property (@(posedge clk) disable iff (rst)
        en_fall |=> stack_sel == $past(sreg[0]) && wiper1_code[WIPER_W-1] == $past(sreg[1])
                    && wiper0_code[WIPER_W-1] == $past(sreg[W0_BASE]));

    // R7
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> sreg == '0 && wiper0_code == '0 && wiper1_code == '0 && !stack_sel);
endmodule

bind wiper_serial_ctrl wsc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_lvl     (en_lvl),
    .shift_pulse(shift_pulse),
    .en_fall    (en_fall),
    .sreg       (sreg),
    .cascade_out(cascade_out),
    .wiper0_code(wiper0_code),
    .wiper1_code(wiper1_code),
    .stack_sel  (stack_sel)
);

// File: tb/tb_wiper_serial_ctrl.sv
`timescale 1ns/1ps
module tb_wiper_serial_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_en = 1'b0;
    logic ser_clk = 1'b0;
    logic host_d = 1'b0;
    logic loop_mode = 1'b0;
    bit   cmp_en = 1'b0;
    bit   done = 1'b0;
    int   checks = 0;
    int   failures = 0;

    always #2.5 clk = ~clk;

    logic       casc [3];
    logic [7:0] w0_o [3];
    logic [7:0] w1_o [3];
    logic [7:0] sel_o [3];
    logic       stk_o [3];
    logic       din [3];

    assign din[0] = loop_mode ? casc[2] : host_d;
    assign din[1] = casc[0];
    assign din[2] = casc[1];

    wiper_serial_ctrl dut (.clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_data(din[0]), .cascade_out(casc[0]), .wiper0_code(w0_o[0]),
        .wiper1_code(w1_o[0]), .stack_sel(stk_o[0]), .wiper_sel_code(sel_o[0]));
    wiper_serial_ctrl dut_b (.clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_data(din[1]), .cascade_out(casc[1]), .wiper0_code(w0_o[1]),
        .wiper1_code(w1_o[1]), .stack_sel(stk_o[1]), .wiper_sel_code(sel_o[1]));
    wiper_serial_ctrl dut_c (.clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_data(din[2]), .cascade_out(casc[2]), .wiper0_code(w0_o[2]),
        .wiper1_code(w1_o[2]), .stack_sel(stk_o[2]), .wiper_sel_code(sel_o[2]));

    // Behavioural model: frame and held image per device (R3 layout)
    logic [16:0] m_frame [3];
    logic [16:0] m_hold [3];
    logic [16:0] img [3];
    logic [50:0] rd_bits, rd_exp;

    function automatic logic [7:0] w1_of(logic [16:0] r);
        logic [7:0] c;
        for (int k = 0; k < 8; k++) c[7-k] = r[1+k];
        return c;
    endfunction

    function automatic logic [7:0] w0_of(logic [16:0] r);
        logic [7:0] c;
        for (int k = 0; k < 8; k++) c[7-k] = r[9+k];
        return c;
    endfunction

    function automatic logic [16:0] mk_img(logic s, logic [7:0] a1, logic [7:0] a0);
        logic [16:0] r;
        r[0] = s;
        for (int k = 0; k < 8; k++) begin
            r[1+k] = a1[7-k];
            r[9+k] = a0[7-k];
        end
        return r;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            for (int i = 0; i < 3; i++) begin
                logic [7:0] e0, e1, es;
                e0 = w0_of(m_hold[i]);
                e1 = w1_of(m_hold[i]);
                es = m_hold[i][0] ? e1 : e0;
                checks++;
                if ({w0_o[i], w1_o[i], stk_o[i], sel_o[i]} !== {e0, e1, m_hold[i][0], es}) begin
                    failures++;
                    $display("FAIL R4 dev%0d actual=%h expected=%h", i,
                        {w0_o[i], w1_o[i], stk_o[i], sel_o[i]}, {e0, e1, m_hold[i][0], es});
                end
                checks++;
                if (casc[i] !== m_frame[i][0]) begin
                    failures++;
                    $display("FAIL R5 dev%0d cascade actual=%b expected=%b", i, casc[i], m_frame[i][0]);
                end
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(logic b);
        logic in0;
        host_d = b;
        wait_clk(4);
        in0 = loop_mode ? m_frame[2][0] : b;
        cmp_en = 1'b0;
        ser_clk = 1'b1;
        wait_clk(6);
        if (ser_en) begin
            m_frame[2] = {m_frame[1][0], m_frame[2][16:1]};
            m_frame[1] = {m_frame[0][0], m_frame[1][16:1]};
            m_frame[0] = {in0, m_frame[0][16:1]};
        end
        cmp_en = 1'b1;
        ser_clk = 1'b0;
        wait_clk(4);
    endtask

    task automatic begin_txn();
        ser_en = 1'b1;
        wait_clk(4);
    endtask

    task automatic end_txn();
        cmp_en = 1'b0;
        ser_en = 1'b0;
        wait_clk(6);
        for (int i = 0; i < 3; i++) m_hold[i] = m_frame[i];
        cmp_en = 1'b1;
        wait_clk(2);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_frame[i] = '0;
            m_hold[i]  = '0;
        end
        wait_clk(10);
        rst = 1'b0;
        wait_clk(2);
        // R7: everything cleared after reset
        for (int i = 0; i < 3; i++) begin
            chk("R7 wiper0 after reset", int'(w0_o[i]), 0);
            chk("R7 wiper1 after reset", int'(w1_o[i]), 0);
            chk("R7 stack/cascade after reset", int'({stk_o[i], casc[i]}), 0);
        end
        cmp_en = 1'b1;

        // R1: clocks and data while enable is low do nothing
        for (int n = 0; n < 12; n++) send_bit(1'b1);
        for (int i = 0; i < 3; i++)
            chk("R1 idle clocks ignored", int'({casc[i], w0_o[i], w1_o[i]}), 0);

        // R2/R3: write three frames down the chain (farthest device first)
        img[0] = mk_img(1'b0, 8'hA5, 8'h3C);
        img[1] = mk_img(1'b1, 8'h81, 8'h7E);
        img[2] = mk_img(1'b0, 8'hFF, 8'h01);
        begin_txn();
        for (int d = 2; d >= 0; d--)
            for (int k = 0; k < 17; k++) send_bit(img[d][k]);
        // R4: outputs still old values before enable falls
        chk("R4 frozen before fall", int'({w0_o[0], w1_o[1], stk_o[1]}), 0);
        chk("R2 cascade shows first-sent bit", int'(casc[1]), int'(img[1][0]));
        end_txn();
        chk("R3 dev0 wiper0", int'(w0_o[0]), 'h3C);
        chk("R3 dev0 wiper1", int'(w1_o[0]), 'hA5);
        chk("R3 dev1 stack", int'(stk_o[1]), 1);
        chk("R3 dev1 wiper0", int'(w0_o[1]), 'h7E);
        chk("R3 dev2 wiper1", int'(w1_o[2]), 'hFF);
        chk("R3 dev2 wiper0", int'(w0_o[2]), 'h01);
        chk("R6 select wiper0 when flag 0", int'(sel_o[0]), 'h3C);
        chk("R6 select wiper1 when flag 1", int'(sel_o[1]), 'h81);

        // R5: looped read restores frames, read stream is each frame bit 0 up
        loop_mode = 1'b1;
        begin_txn();
        for (int s = 0; s < 51; s++) begin
            rd_bits[s] = casc[2];
            rd_exp[s]  = img[2 - s/17][s%17];
            send_bit(1'b0);
        end
        end_txn();
        loop_mode = 1'b0;
        chk("R5 loop read stream low", int'(rd_bits[31:0]), int'(rd_exp[31:0]));
        chk("R5 loop read stream high", int'(rd_bits[50:32]), int'(rd_exp[50:32]));
        chk("R5 dev0 restored", int'({w1_o[0], w0_o[0]}), 'hA53C);
        chk("R5 dev1 restored", int'({stk_o[1], w1_o[1], w0_o[1]}), 'h1817E);
        for (int i = 0; i < 3; i++)
            chk("R5 idle cascade equals flag", int'(casc[i]), int'(img[i][0]));

        // R4: enable pulse with no clocks reloads the same frame
        begin_txn();
        end_txn();
        chk("R4 empty transaction keeps dev2", int'({w1_o[2], w0_o[2]}), 'hFF01);

        // R8: 5-bit partial transaction still transfers
        begin_txn();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        end_txn();
        chk("R8 partial frame flag", int'(stk_o[0]), int'(img[0][5]));
        chk("R8 partial wiper0", int'(w0_o[0]),
            int'(w0_of({1'b0, 1'b1, 1'b1, 1'b0, 1'b1, img[0][16:5]})));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule